// File: doc/BRIEF.md
# Codec Link Reset and Status Controller

This block is the control and status register unit for a serial audio/modem codec link. A simple register bus reaches two 32-bit registers. The control register drives the active-low cold reset pin, requests a warm reset, shuts the link off, and holds the interrupt enables. The status register collects sticky event flags and reports whether the codec bit clock is running. The block drives a single combined interrupt line. Slot framing, serialisation and DMA sit outside it. The frame sync and serial data produced by the framer pass through this block so that warm reset and shut-off can override them.

The bit clock comes from the codec and is asynchronous. A two-flop synchroniser feeds an edge detector. A counter in the system clock domain declares the clock absent after `ABSENT_CYC` cycles with no edge. A warm reset is allowed only while the clock is absent. It holds SYNC high for `PULSE_CYC` system cycles, which is about 1 µs at the default setting. It then waits until the clock is detected again, and only then does the request bit clear itself.

Top module: `codec_link_ctl`

## Requirements
- R1: During and right after reset, the control word (offset 0x00) and the status word (offset 0x04) both read 0. The irq, link_rst_n, link_sync, link_sdout and link_in_en outputs are all 0.
- R2: Control bits 31:6 always read 0, whatever was written to them. Status bits other than 0, 8, 9, 15 and 28 read 0. A read from an address that is not mapped returns 0.
- R3: Control bit 1 is the cold reset control, active low. link_rst_n follows the written value one cycle after the write. Bit 1 reads back the level of the link_rst_n pin.
- R4: A pulse on sleep_enter forces the cold reset control to 0, and link_rst_n goes low on the next cycle. sleep_enter takes priority over a bus write in the same cycle.
- R5: A write of 1 to control bit 2 while the bit clock is detected has no effect. Bit 2 stays 0 and link_sync shows no pulse.
- R6: A write of 1 to control bit 2 while the bit clock is absent sets bit 2. link_sync is then held high for exactly PULSE_CYC cycles, starting one cycle after the write. Bit 2 stays 1 until the pulse is over and the bit clock is detected, and then it clears itself.
- R7: Status bit 28 reads 1 once bit clock edges arrive. It reads 0 after ABSENT_CYC consecutive system cycles with no synchronised edge.
- R8: While control bit 3 (shut-off) is 1, link_rst_n, link_sync and link_sdout are driven low and link_in_en is 0, one cycle after the register changes.
- R9: A pulse on gpi_change sets status bit 0 whatever the enable. irq rises one cycle after the flag only when control bit 0 is 1.
- R10: Pulses on pri_resume and sec_resume set status bits 8 and 9. Each one adds to irq only when its enable is set: control bit 4 for bit 8, control bit 5 for bit 9.
- R11: A pulse on rd_timeout sets status bit 15. The bit stays set until it is cleared and never raises irq.
- R12: Status flags are cleared by writing 1 to their bit. Writing 0 leaves them unchanged. An event in the same cycle as a clear leaves the flag set.
- R13: When shut-off is 0 and no warm pulse is in progress, link_sync and link_sdout follow frame_sync_in and sdout_in with one cycle of latency, and link_in_en is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high platform reset |
| sleep_enter | input | 1 | Sleep-state entry pulse, forces cold reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address of register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| bit_clk | input | 1 | Codec bit clock, asynchronous |
| frame_sync_in | input | 1 | Frame sync from the link framer |
| sdout_in | input | 1 | Serial data from the link framer |
| gpi_change | input | 1 | General-purpose input change pulse |
| pri_resume | input | 1 | Primary codec resume pulse |
| sec_resume | input | 1 | Secondary codec resume pulse |
| rd_timeout | input | 1 | Codec read timeout pulse |
| link_rst_n | output | 1 | Cold reset pin, active low |
| link_sync | output | 1 | SYNC pin |
| link_sdout | output | 1 | Serial data out pin |
| link_in_en | output | 1 | Input buffer enable |
| irq | output | 1 | Combined interrupt |

## Verification
Several rules are checked on every cycle by the embedded assertions:
- the warm request bit only rises while the bit clock is absent, and only falls once the clock is detected;
- shut-off silences every link output on the following cycle;
- sleep entry clears the cold reset control;
- a pending status flag with no clear stays set;
- a synchronised edge marks the clock present;
- reserved control bits read zero.

Other behaviour only the bench scenarios can show. These are the exact SYNC pulse length, the absence timeout after the clock stops, the mapping of enables to interrupt sources, the event-wins-over-clear ordering, and the priority of sleep over bus writes.

// File: rtl/codec_link_pkg.sv
package codec_link_pkg;
  localparam int REG_W = 32;

  localparam logic [7:0] CTRL_OFS = 8'h00;
  localparam logic [7:0] STAT_OFS = 8'h04;

  // control word bit positions
  localparam int C_GPI_EN  = 0;
  localparam int C_COLD_N  = 1;
  localparam int C_WARM    = 2;
  localparam int C_SHUTOFF = 3;
  localparam int C_PRI_EN  = 4;
  localparam int C_SEC_EN  = 5;

  // sticky event sources, index into the event vector
  localparam int NUM_EV  = 4;
  localparam int EV_GPI  = 0;
  localparam int EV_PRI  = 1;
  localparam int EV_SEC  = 2;
  localparam int EV_TOUT = 3;

  localparam int S_CLK_PRESENT = 28;

  function automatic int ev_bit(input int idx);
    case (idx)
      EV_GPI:  return 0;
      EV_PRI:  return 8;
      EV_SEC:  return 9;
      default: return 15;
    endcase
  endfunction

  typedef enum logic [1:0] {
    WR_IDLE  = 2'd0,
    WR_PULSE = 2'd1,
    WR_WAIT  = 2'd2
  } warm_state_e;
endpackage

// File: rtl/clk_presence_det.sv
module clk_presence_det #(
  parameter int ABSENT_CYC = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_clk,
  output logic present
);
  localparam int CNT_W = (ABSENT_CYC > 1) ? $clog2(ABSENT_CYC) : 1;

  logic             s1, s2, s3;
  logic             edge_seen;
  logic [CNT_W-1:0] idle_cnt;

  assign edge_seen = s2 ^ s3;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1       <= 1'b0;
      s2       <= 1'b0;
      s3       <= 1'b0;
      idle_cnt <= '0;
      present  <= 1'b0;
    end else begin
      s1 <= bit_clk;
      s2 <= s1;
      s3 <= s2;
      if (edge_seen) begin
        idle_cnt <= '0;
        present  <= 1'b1;
      end else if (idle_cnt == CNT_W'(ABSENT_CYC - 1)) begin
        present  <= 1'b0;
      end else begin
        idle_cnt <= idle_cnt + 1'b1;
      end
    end
  end

  assert_edge_present_R7: assert property (@(posedge clk) disable iff (rst)
    edge_seen |=> present);
endmodule

// File: rtl/warm_reset_seq.sv
module warm_reset_seq
  import codec_link_pkg::*;
#(
  parameter int PULSE_CYC = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic clk_present,
  output logic busy,
  output logic sync_force
);
  localparam int PC_W = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1;

  warm_state_e      state;
  logic [PC_W-1:0]  pcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= WR_IDLE;
      pcnt  <= '0;
    end else begin
      case (state)
        WR_IDLE: if (start) begin
          state <= WR_PULSE;
          pcnt  <= '0;
        end
        WR_PULSE: if (pcnt == PC_W'(PULSE_CYC - 1)) state <= WR_WAIT;
                  else pcnt <= pcnt + 1'b1;
        WR_WAIT: if (clk_present) state <= WR_IDLE;
        default: state <= WR_IDLE;
      endcase
    end
  end

  assign busy       = (state != WR_IDLE);
  assign sync_force = (state == WR_PULSE);

  assert_wait_after_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    (state == WR_PULSE && $past(state) == WR_IDLE) |-> $past(start));
endmodule

// File: rtl/link_status_regs.sv
module link_status_regs #(
  parameter int NUM_EV = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_EV-1:0] ev_set,
  input  logic [NUM_EV-1:0] ev_clr,
  input  logic [NUM_EV-1:0] ev_en,
  output logic [NUM_EV-1:0] flags,
  output logic              irq_q
);
  for (genvar i = 0; i < NUM_EV; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)             flags[i] <= 1'b0;
      else if (ev_set[i])  flags[i] <= 1'b1;
      else if (ev_clr[i])  flags[i] <= 1'b0;
    end

    assert_flag_sticky_R12: assert property (@(posedge clk) disable iff (rst)
      (flags[i] && !ev_clr[i]) |=> flags[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(flags & ev_en);
  end
endmodule

// File: rtl/codec_link_ctl.sv
module codec_link_ctl
  import codec_link_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int ABSENT_CYC = 64,
  parameter int PULSE_CYC  = 100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sleep_enter,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              bit_clk,
  input  logic              frame_sync_in,
  input  logic              sdout_in,
  input  logic              gpi_change,
  input  logic              pri_resume,
  input  logic              sec_resume,
  input  logic              rd_timeout,
  output logic              link_rst_n,
  output logic              link_sync,
  output logic              link_sdout,
  output logic              link_in_en,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFS);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_OFS);

  logic is_ctrl, is_stat, wr_ctrl, wr_stat;
  logic gie, cold_n, shutoff, pri_en, sec_en;
  logic clk_present, warm_busy, sync_force, warm_start;
  logic [NUM_EV-1:0] ev_set, ev_clr, ev_en, flags;
  logic [REG_W-1:0]  ctrl_word, stat_word;

  assign is_ctrl = (bus_addr == A_CTRL);
  assign is_stat = (bus_addr == A_STAT);
  assign wr_ctrl = bus_wr && is_ctrl;
  assign wr_stat = bus_wr && is_stat;

  clk_presence_det #(.ABSENT_CYC(ABSENT_CYC)) i_det (
    .clk(clk), .rst(rst), .bit_clk(bit_clk), .present(clk_present)
  );

  assign warm_start = wr_ctrl && bus_wdata[C_WARM] && !clk_present;

  warm_reset_seq #(.PULSE_CYC(PULSE_CYC)) i_warm (
    .clk(clk), .rst(rst), .start(warm_start), .clk_present(clk_present),
    .busy(warm_busy), .sync_force(sync_force)
  );

  // control fields
  always_ff @(posedge clk) begin
    if (rst) begin
      gie     <= 1'b0;
      cold_n  <= 1'b0;
      shutoff <= 1'b0;
      pri_en  <= 1'b0;
      sec_en  <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        gie     <= bus_wdata[C_GPI_EN];
        shutoff <= bus_wdata[C_SHUTOFF];
        pri_en  <= bus_wdata[C_PRI_EN];
        sec_en  <= bus_wdata[C_SEC_EN];
      end
      if (sleep_enter)  cold_n <= 1'b0;
      else if (wr_ctrl) cold_n <= bus_wdata[C_COLD_N];
    end
  end

  // status events
  always_comb begin
    ev_set          = '0;
    ev_set[EV_GPI]  = gpi_change;
    ev_set[EV_PRI]  = pri_resume;
    ev_set[EV_SEC]  = sec_resume;
    ev_set[EV_TOUT] = rd_timeout;
    ev_en           = '0;
    ev_en[EV_GPI]   = gie;
    ev_en[EV_PRI]   = pri_en;
    ev_en[EV_SEC]   = sec_en;
    for (int i = 0; i < NUM_EV; i++)
      ev_clr[i] = wr_stat && bus_wdata[ev_bit(i)];
  end

  link_status_regs #(.NUM_EV(NUM_EV)) i_stat (
    .clk(clk), .rst(rst), .ev_set(ev_set), .ev_clr(ev_clr), .ev_en(ev_en),
    .flags(flags), .irq_q(irq)
  );

  // link pins
  always_ff @(posedge clk) begin
    if (rst) begin
      link_rst_n <= 1'b0;
      link_sync  <= 1'b0;
      link_sdout <= 1'b0;
      link_in_en <= 1'b0;
    end else begin
      link_rst_n <= !shutoff && cold_n;
      link_sync  <= !shutoff && (sync_force || frame_sync_in);
      link_sdout <= !shutoff && sdout_in;
      link_in_en <= !shutoff;
    end
  end

  // read path
  always_comb begin
    ctrl_word            = '0;
    ctrl_word[C_GPI_EN]  = gie;
    ctrl_word[C_COLD_N]  = link_rst_n;
    ctrl_word[C_WARM]    = warm_busy;
    ctrl_word[C_SHUTOFF] = shutoff;
    ctrl_word[C_PRI_EN]  = pri_en;
    ctrl_word[C_SEC_EN]  = sec_en;
    stat_word            = '0;
    for (int i = 0; i < NUM_EV; i++) stat_word[ev_bit(i)] = flags[i];
    stat_word[S_CLK_PRESENT] = clk_present;
  end

  always_ff @(posedge clk) begin
    if (rst)          bus_rdata <= '0;
    else if (bus_rd)  bus_rdata <= is_ctrl ? ctrl_word : (is_stat ? stat_word : '0);
  end

  assert_warm_reject_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(warm_busy) |-> $past(!clk_present));

  assert_warm_clear_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(warm_busy) |-> $past(clk_present));

  assert_shutoff_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    shutoff |=> (!link_rst_n && !link_sync && !link_sdout && !link_in_en));

  assert_sleep_cold_R4: assert property (@(posedge clk) disable iff (rst)
    sleep_enter |=> !cold_n);

  assert_ctrl_rsvd_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && is_ctrl) |=> (bus_rdata[31:6] == '0));
endmodule

// File: tb/test_codec_link_ctl.sv
module test_codec_link_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int ABSENT     = 64;
  localparam int PULSE      = 100;
  localparam int BCLK_HALF  = 3;

  logic clk = 0, rst = 1;
  logic sleep_enter = 0, bus_wr = 0, bus_rd = 0;
  logic [7:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic bit_clk = 0, frame_sync_in = 0, sdout_in = 0;
  logic gpi_change = 0, pri_resume = 0, sec_resume = 0, rd_timeout = 0;
  logic link_rst_n, link_sync, link_sdout, link_in_en, irq;

  int checks = 0, errors = 0;
  bit bclk_run = 0;
  int bclk_div = 0;

  codec_link_ctl #(.ADDR_W(8), .ABSENT_CYC(ABSENT), .PULSE_CYC(PULSE)) i_codec_link_ctl (
    .clk(clk), .rst(rst), .sleep_enter(sleep_enter), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bit_clk(bit_clk), .frame_sync_in(frame_sync_in), .sdout_in(sdout_in),
    .gpi_change(gpi_change), .pri_resume(pri_resume), .sec_resume(sec_resume),
    .rd_timeout(rd_timeout), .link_rst_n(link_rst_n), .link_sync(link_sync),
    .link_sdout(link_sdout), .link_in_en(link_in_en), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (bclk_run) begin
      bclk_div++;
      if (bclk_div >= BCLK_HALF) begin
        bclk_div = 0;
        bit_clk  = ~bit_clk;
      end
    end
  end

  // ---------------- behavioural reference model ----------------
  bit smp[$];
  int m_since; bit m_seen;
  int m_phase;          // 0 idle, 1 pulsing, 2 waiting for clock
  int m_left;
  bit m_gie, m_cold, m_shut, m_pri, m_sec;
  bit m_fl[4];
  bit m_pin_rst, m_pin_sync, m_pin_sdo, m_pin_in, m_irq;
  logic [31:0] m_rdata;

  function automatic bit m_present();
    return m_seen && (m_since < ABSENT);
  endfunction

  function automatic int flag_pos(int i);
    int p[4] = '{0, 8, 9, 15};
    return p[i];
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      smp = '{}; m_since = 0; m_seen = 0; m_phase = 0; m_left = 0;
      m_gie = 0; m_cold = 0; m_shut = 0; m_pri = 0; m_sec = 0;
      for (int i = 0; i < 4; i++) m_fl[i] = 0;
      m_pin_rst = 0; m_pin_sync = 0; m_pin_sdo = 0; m_pin_in = 0; m_irq = 0;
      m_rdata = 0;
    end else begin
      bit pres_old, edge_now, wr_c, wr_s, ev[4], pulsing_old;
      logic [31:0] cw, sw;
      pres_old    = m_present();
      pulsing_old = (m_phase == 1);
      wr_c = bus_wr && bus_addr == 8'h00;
      wr_s = bus_wr && bus_addr == 8'h04;
      // read data from pre-edge state
      cw = 0; cw[0] = m_gie; cw[1] = m_pin_rst; cw[2] = (m_phase != 0);
      cw[3] = m_shut; cw[4] = m_pri; cw[5] = m_sec;
      sw = 0; for (int i = 0; i < 4; i++) sw[flag_pos(i)] = m_fl[i];
      sw[28] = pres_old;
      if (bus_rd) m_rdata = (bus_addr == 8'h00) ? cw : ((bus_addr == 8'h04) ? sw : 32'h0);
      // pins and irq from pre-edge state
      m_irq      = (m_fl[0] && m_gie) || (m_fl[1] && m_pri) || (m_fl[2] && m_sec);
      m_pin_rst  = !m_shut && m_cold;
      m_pin_sync = !m_shut && (pulsing_old || frame_sync_in);
      m_pin_sdo  = !m_shut && sdout_in;
      m_pin_in   = !m_shut;
      // warm sequence
      case (m_phase)
        0: if (wr_c && bus_wdata[2] && !pres_old) begin m_phase = 1; m_left = PULSE; end
        1: begin m_left--; if (m_left == 0) m_phase = 2; end
        default: if (pres_old) m_phase = 0;
      endcase
      // status flags: event beats clear
      ev = '{gpi_change, pri_resume, sec_resume, rd_timeout};
      for (int i = 0; i < 4; i++)
        if (ev[i]) m_fl[i] = 1;
        else if (wr_s && bus_wdata[flag_pos(i)]) m_fl[i] = 0;
      if (wr_c) begin
        m_gie = bus_wdata[0]; m_shut = bus_wdata[3];
        m_pri = bus_wdata[4]; m_sec = bus_wdata[5];
      end
      if (sleep_enter) m_cold = 0; else if (wr_c) m_cold = bus_wdata[1];
      // clock presence: two-stage sync then compare neighbouring samples
      edge_now = (smp.size() >= 3) ? (smp[smp.size()-2] != smp[smp.size()-3]) : 1'b0;
      if (smp.size() == 2) edge_now = smp[0];
      if (smp.size() == 1) edge_now = 1'b0;
      smp.push_back(bit_clk);
      if (smp.size() > 4) void'(smp.pop_front());
      if (edge_now) begin m_seen = 1; m_since = 0; end
      else if (m_since < ABSENT) m_since++;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if ({link_rst_n, link_sync, link_sdout, link_in_en, irq} !==
          {m_pin_rst, m_pin_sync, m_pin_sdo, m_pin_in, m_irq}) begin
        errors++;
        $display("FAIL R3/R8/R13 pins rst,sync,sdo,in,irq act=%b exp=%b",
          {link_rst_n, link_sync, link_sdout, link_in_en, irq},
          {m_pin_rst, m_pin_sync, m_pin_sdo, m_pin_in, m_irq});
      end
      checks++;
      if (bus_rdata !== m_rdata) begin
        errors++;
        $display("FAIL R2/R12 rdata act=%h exp=%h", bus_rdata, m_rdata);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0; bus_wdata = 0;
    @(negedge clk);
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
    d = bus_rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    int cnt;
    repeat (4) @(negedge clk);
    rst = 0;
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 pin rst", {31'b0, link_rst_n}, 0);
    rd(8'h00, d); chk("R1 ctrl", d, 0);
    rd(8'h04, d); chk("R1 stat", d, 0);

    // R2, R3
    wr(8'h00, 32'hFFFF_FFC2);
    rd(8'h00, d); chk("R2 R3 ctrl reserved/cold", d, 32'h2);
    chk("R3 pin high", {31'b0, link_rst_n}, 1);
    rd(8'h10, d); chk("R2 unmapped", d, 0);
    wr(8'h00, 32'h0);
    chk("R3 pin low", {31'b0, link_rst_n}, 0);
    wr(8'h00, 32'h2);

    // R9, R12
    gpi_change = 1; @(negedge clk); gpi_change = 0; idle(1);
    rd(8'h04, d); chk("R9 gpi flag, disabled", d, 32'h1);
    chk("R9 irq off", {31'b0, irq}, 0);
    wr(8'h00, 32'h3);
    chk("R9 irq on", {31'b0, irq}, 1);
    wr(8'h04, 32'h0);
    rd(8'h04, d); chk("R12 write 0 keeps", d, 32'h1);
    wr(8'h04, 32'h1);
    rd(8'h04, d); chk("R12 write 1 clears", d, 0);
    chk("R9 irq cleared", {31'b0, irq}, 0);

    // R10
    wr(8'h00, 32'h12);
    pri_resume = 1; @(negedge clk); pri_resume = 0; idle(1);
    rd(8'h04, d); chk("R10 pri flag", d, 32'h100);
    chk("R10 pri irq", {31'b0, irq}, 1);
    sec_resume = 1; @(negedge clk); sec_resume = 0; idle(1);
    wr(8'h04, 32'h100);
    rd(8'h04, d); chk("R10 sec flag kept", d, 32'h200);
    chk("R10 sec disabled irq", {31'b0, irq}, 0);
    wr(8'h00, 32'h22); idle(1);
    chk("R10 sec enabled irq", {31'b0, irq}, 1);
    wr(8'h04, 32'h200);

    // R11, R12
    rd_timeout = 1; @(negedge clk); rd_timeout = 0;
    idle(20);
    rd(8'h04, d); chk("R11 timeout sticky", d, 32'h8000);
    chk("R11 no irq", {31'b0, irq}, 0);
    rd_timeout = 1; bus_wr = 1; bus_addr = 8'h04; bus_wdata = 32'h8000;
    @(negedge clk); rd_timeout = 0; bus_wr = 0; bus_wdata = 0;
    rd(8'h04, d); chk("R12 event beats clear", d, 32'h8000);
    wr(8'h04, 32'h8000);
    rd(8'h04, d); chk("R11 cleared", d, 0);

    // R7, R5
    wr(8'h00, 32'h2);
    bclk_run = 1; idle(20);
    rd(8'h04, d); chk("R7 clock present", d, 32'h1000_0000);
    wr(8'h00, 32'h6);
    cnt = 0;
    for (int i = 0; i < PULSE; i++) begin
      if (link_sync) cnt++;
      @(negedge clk);
    end
    chk("R5 no sync pulse", cnt, 0);
    rd(8'h00, d); chk("R5 warm ignored", d, 32'h2);

    // R7 absence, R6
    bclk_run = 0; idle(ABSENT + 10);
    rd(8'h04, d); chk("R7 clock absent", d, 0);
    wr(8'h00, 32'h6);
    cnt = 0;
    for (int i = 0; i < PULSE + 20; i++) begin
      if (link_sync) cnt++;
      @(negedge clk);
    end
    chk("R6 sync pulse length", cnt, PULSE);
    rd(8'h00, d); chk("R6 warm held without clock", d, 32'h6);
    bclk_run = 1; idle(20);
    rd(8'h00, d); chk("R6 warm self-clear", d, 32'h2);

    // R4
    sleep_enter = 1; bus_wr = 1; bus_addr = 8'h00; bus_wdata = 32'h2;
    @(negedge clk); sleep_enter = 0; bus_wr = 0; bus_wdata = 0;
    idle(1);
    chk("R4 pin low", {31'b0, link_rst_n}, 0);
    rd(8'h00, d); chk("R4 cold bit", d, 0);

    // R8, R13
    wr(8'h00, 32'h2);
    frame_sync_in = 1; sdout_in = 1; idle(1);
    chk("R13 pass-through", {28'b0, link_rst_n, link_sync, link_sdout, link_in_en}, 32'hF);
    wr(8'h00, 32'hA);
    chk("R8 shut-off", {28'b0, link_rst_n, link_sync, link_sdout, link_in_en}, 32'h0);
    wr(8'h00, 32'h2);
    chk("R8 R13 restored", {28'b0, link_rst_n, link_sync, link_sdout, link_in_en}, 32'hF);
    frame_sync_in = 0; idle(1);
    chk("R13 sync follows", {31'b0, link_sync}, 0);

    idle(3);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule